// File: doc/BRIEF.md
# Three-Wire Serial Register Access Master

This block performs single register transactions over a half-duplex serial link that uses one shared data wire. A requester pulses `start` together with a direction flag, a register address and (for writes) a data byte. The block then lowers the active-low select, clocks out a command word and either sends the data byte or receives one from the remote device. At the end it raises select again and pulses `done` for one clock. For reads, the received byte appears on `rdata` in that same cycle.

The shared data wire is modelled as three pins: an output value, an output enable and an input value, which the chip's pad ring joins into one bidirectional line. The command word is eight clocks long. It holds the address, then a direction bit, then a final slot. On writes the master drives that slot as a zero pad. On reads the master leaves the line undriven in that slot so the remote device can take it over. The serial clock runs at the system clock divided by `2*CLK_DIV`.

Top module: `tws_master`

## Requirements
- R1: After reset, and whenever no transaction is in progress, `cs_n` is 1, `sclk` is 0, `sdo_oe` is 0, `done` is 0 and `busy` is 0.
- R2: The first six serial clocks carry the register address, most significant bit first.
- R3: The seventh serial clock carries the direction bit: 0 for a write, 1 for a read.
- R4: On a write, the eighth clock carries a 0 pad bit and clocks 9 to 16 carry `wdata` MSB first, with `sdo_oe` high for all 16 clocks.
- R5: On a read, `sdo_oe` is high for clocks 1 to 7 and low from the eighth clock (the turnaround slot) to the end of the transaction.
- R6: On a read, `sdi` is sampled on the rising edges of clocks 9 to 16, MSB first, and the byte appears on `rdata` when `done` is high. A write leaves `rdata` unchanged.
- R7: `sclk` idles low, each half period lasts exactly `CLK_DIV` system clocks, and `sdo` changes only while `sclk` is low. The master changes data on the falling edge and samples on the rising edge.
- R8: Each transaction has exactly 16 rising `sclk` edges. `cs_n` falls `CLK_DIV` system clocks before the first rising edge and rises `CLK_DIV` system clocks after the last falling edge.
- R9: `done` is a single-cycle pulse in the cycle where `cs_n` returns high. `busy` is high from the cycle after `start` is accepted until that cycle.
- R10: A `start` pulse while `busy` is high is ignored. It does not change the frame in progress, and no second transaction follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted only when idle |
| wr | input | 1 | 1 = register write, 0 = register read |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Byte to write |
| rdata | output | DATA_W | Last byte read |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transaction in progress |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low device select |
| sdo | output | 1 | Serial data toward the shared line |
| sdo_oe | output | 1 | Drive enable for the shared line |
| sdi | input | 1 | Serial data read back from the shared line |

## Verification
The bench builds the block with `CLK_DIV` = 3, with address and data widths at their defaults of 6 and 8. With an odd divider that is larger than one, the divider counter wraps at a value that is not a power of two. The half-period, select-setup and select-hold intervals can then each be measured as exactly three system clocks, and a wrong count would show. A behavioural remote device in the bench drives the line only after the turnaround slot, so any overlap of drivers shows up as a wrong enable pattern. Requests injected in the middle of a frame test that such requests are ignored.

// File: rtl/tws_pkg.sv
package tws_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_TAIL = 2'd2
   } tws_state_e;
endpackage

// File: rtl/tws_tick.sv
module tws_tick #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   generate
      if (DIV < 1) begin : g_bad_div
         $error("tws_tick: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_every
         assign tick = en;
      end else begin : g_count
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] TOP = CW'(DIV - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt <= '0;
            else if (!en)        cnt <= '0;
            else if (cnt == TOP) cnt <= '0;
            else                 cnt <= cnt + 1'b1;
         end
         assign tick = en && (cnt == TOP);

         a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= TOP);
      end
   endgenerate
endmodule

// File: rtl/tws_shift.sv
module tws_shift #(
   parameter int FRAME_W = 16,
   parameter int RX_W    = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] load_val,
   input  logic               shift,
   input  logic               sample,
   input  logic               sdi,
   output logic               tx_bit,
   output logic [RX_W-1:0]    rx_word
);
   generate
      if (RX_W > FRAME_W) begin : g_bad_w
         $error("tws_shift: RX_W exceeds FRAME_W");
      end
   endgenerate

   logic [FRAME_W-1:0] tx_q;
   logic [RX_W-1:0]    rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tx_q <= '0;
      else if (load)  tx_q <= load_val;
      else if (shift) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rx_q <= '0;
      else if (sample) rx_q <= {rx_q[RX_W-2:0], sdi};
   end

   assign tx_bit  = tx_q[FRAME_W-1];
   assign rx_word = rx_q;

   a_r7_no_load_shift_clash: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && shift));
endmodule

// File: rtl/tws_master.sv
module tws_master #(
   parameter int ADDR_W  = 6,
   parameter int DATA_W  = 8,
   parameter int CLK_DIV = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              done,
   output logic              busy,
   output logic              sclk,
   output logic              cs_n,
   output logic              sdo,
   output logic              sdo_oe,
   input  logic              sdi
);
   import tws_pkg::*;

   localparam int CMD_W   = ADDR_W + 2;
   localparam int FRAME_W = CMD_W + DATA_W;
   localparam int IDX_W   = $clog2(FRAME_W);
   localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_W - 1);
   localparam logic [IDX_W-1:0] PRE_TURN  = IDX_W'(CMD_W - 2);
   localparam logic [IDX_W-1:0] FIRST_RX  = IDX_W'(CMD_W);

   generate
      if (ADDR_W < 1 || DATA_W < 2) begin : g_bad_w
         $error("tws_master: ADDR_W must be >= 1 and DATA_W >= 2");
      end
      if (CLK_DIV < 1) begin : g_bad_div
         $error("tws_master: CLK_DIV must be at least 1");
      end
   endgenerate

   tws_state_e       state;
   logic             wr_q;
   logic [IDX_W-1:0] bit_idx;
   logic             tick;
   logic             accept, shift_en, sample_en;
   logic [FRAME_W-1:0] frame_val;
   logic [DATA_W-1:0]  rx_word;
   logic             tx_bit;

   assign accept    = (state == ST_IDLE) && start;
   assign shift_en  = (state == ST_RUN) && tick && sclk && (bit_idx != LAST_IDX);
   assign sample_en = (state == ST_RUN) && tick && !sclk && !wr_q && (bit_idx >= FIRST_RX);
   assign frame_val = wr ? {addr, 1'b0, 1'b0, wdata}
                         : {addr, 1'b1, 1'b0, {DATA_W{1'b0}}};

   tws_tick #(.DIV(CLK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (state != ST_IDLE),
      .tick  (tick)
   );

   tws_shift #(.FRAME_W(FRAME_W), .RX_W(DATA_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (frame_val),
      .shift    (shift_en),
      .sample   (sample_en),
      .sdi      (sdi),
      .tx_bit   (tx_bit),
      .rx_word  (rx_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         wr_q    <= 1'b0;
         bit_idx <= '0;
         sclk    <= 1'b0;
         cs_n    <= 1'b1;
         sdo_oe  <= 1'b0;
         done    <= 1'b0;
         rdata   <= '0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  wr_q    <= wr;
                  bit_idx <= '0;
                  sclk    <= 1'b0;
                  cs_n    <= 1'b0;
                  sdo_oe  <= 1'b1;
                  state   <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (tick) begin
                  if (!sclk) begin
                     sclk <= 1'b1;
                  end else begin
                     sclk <= 1'b0;
                     if (bit_idx == LAST_IDX) begin
                        sdo_oe <= 1'b0;
                        state  <= ST_TAIL;
                     end else begin
                        bit_idx <= bit_idx + 1'b1;
                        if (!wr_q && bit_idx == PRE_TURN) sdo_oe <= 1'b0;
                     end
                  end
               end
            end
            ST_TAIL: begin
               if (tick) begin
                  cs_n  <= 1'b1;
                  done  <= 1'b1;
                  state <= ST_IDLE;
                  if (!wr_q) rdata <= rx_word;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state != ST_IDLE);
   assign sdo  = tx_bit;

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> (cs_n && !sclk && !sdo_oe));
   a_r8_sclk_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> !cs_n);
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r9_done_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cs_n && $past(!cs_n)));
   a_r4_write_keeps_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && wr_q) |-> sdo_oe);
   a_r7_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(sdo));
endmodule

// File: tb/tws_master_tb.sv
module tws_master_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DIV = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic wr = 1'b0;
   logic [5:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic done, busy, sclk, cs_n, sdo, sdo_oe;
   logic sdi = 1'b1;

   int checks = 0;
   int fails = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tws_master #(.ADDR_W(6), .DATA_W(8), .CLK_DIV(DIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .addr(addr),
      .wdata(wdata), .rdata(rdata), .done(done), .busy(busy), .sclk(sclk),
      .cs_n(cs_n), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi)
   );

   // line monitor and remote device model
   int mon_n = 0;
   logic [15:0] bits, oes;
   logic [7:0] dev_val = '0;

   always @(posedge sclk) begin
      if (mon_n < 16) begin
         bits[15-mon_n] = sdo;
         oes[15-mon_n]  = sdo_oe;
      end
      mon_n = mon_n + 1;
   end

   always @(negedge sclk) begin
      if (mon_n >= 8 && mon_n < 16) sdi = dev_val[15-mon_n];
      else sdi = 1'b1;
   end

   // interval, hold and pulse monitors, sampled between edges
   logic prev_sclk = 1'b0, prev_cs = 1'b1, prev_sdo = 1'b0;
   int gap = 0;
   int timing_err = 0, hold_err = 0, done_err = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         gap = gap + 1;
         if (sclk != prev_sclk || cs_n != prev_cs) begin
            if (!prev_cs && gap != DIV) timing_err = timing_err + 1;
            gap = 0;
         end
         if (sclk && prev_sclk && sdo != prev_sdo) hold_err = hold_err + 1;
         if (done && !(cs_n && !prev_cs)) done_err = done_err + 1;
      end
      prev_sclk = sclk;
      prev_cs   = cs_n;
      prev_sdo  = sdo;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic pulse_start(input logic w, input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      start = 1'b1; wr = w; addr = a; wdata = d;
      @(negedge clk);
      start = 1'b0;
   endtask

   // one transaction; checks frame, drive pattern, timing and result
   task automatic run_xfer(input logic w, input logic [5:0] a, input logic [7:0] d,
                           input logic [7:0] dv, input bit inject);
      logic [7:0] rd_before;
      rd_before = rdata;
      mon_n = 0; timing_err = 0; hold_err = 0; done_err = 0;
      dev_val = dv;
      pulse_start(w, a, d);
      chk(busy === 1'b1, "R9 busy after start", int'(busy), 1);
      if (inject) begin
         repeat (10) @(negedge clk);
         start = 1'b1; wr = ~w; addr = ~a; wdata = ~d;
         @(negedge clk);
         start = 1'b0;
      end
      while (done !== 1'b1) @(negedge clk);
      chk(busy === 1'b0, "R9 busy low at done", int'(busy), 0);
      chk(mon_n == 16, "R8 rising edge count", mon_n, 16);
      chk(bits[15:10] == a, "R2 address bits", int'(bits[15:10]), int'(a));
      chk(bits[9] == ~w, "R3 direction bit", int'(bits[9]), int'(~w));
      if (w) begin
         chk(bits[8] == 1'b0, "R4 pad bit", int'(bits[8]), 0);
         chk(bits[7:0] == d, "R4 write data", int'(bits[7:0]), int'(d));
         chk(oes == 16'hFFFF, "R4 drive enable", int'(oes), 16'hFFFF);
         chk(rdata == rd_before, "R6 write keeps rdata", int'(rdata), int'(rd_before));
      end else begin
         chk(oes == 16'hFE00, "R5 turnaround enable", int'(oes), 16'hFE00);
         chk(rdata == dv, "R6 read data", int'(rdata), int'(dv));
      end
      chk(timing_err == 0, "R7 R8 interval count", timing_err, 0);
      chk(hold_err == 0, "R7 data hold while high", hold_err, 0);
      chk(done_err == 0, "R9 done with cs rise", done_err, 0);
      @(negedge clk);
      chk(done === 1'b0, "R9 done one cycle", int'(done), 0);
      repeat (8*DIV) @(negedge clk);
      chk(cs_n === 1'b1 && sclk === 1'b0 && sdo_oe === 1'b0, "R1 idle after frame",
          int'({cs_n, sclk, sdo_oe}), 3'b100);
      if (inject)
         chk(mon_n == 16 && busy === 1'b0, "R10 busy request ignored", mon_n, 16);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(cs_n === 1'b1 && sclk === 1'b0 && sdo_oe === 1'b0 && done === 1'b0 && busy === 1'b0,
          "R1 reset state", int'({cs_n, sclk, sdo_oe, done, busy}), 5'b10000);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      run_xfer(1'b1, 6'h2A, 8'hA5, 8'h00, 1'b0);
      run_xfer(1'b0, 6'h15, 8'h00, 8'h3C, 1'b0);
      run_xfer(1'b1, 6'h3F, 8'hFF, 8'h00, 1'b0);
      run_xfer(1'b0, 6'h00, 8'h00, 8'h81, 1'b1);
      run_xfer(1'b1, 6'h00, 8'h00, 8'hFF, 1'b1);
      run_xfer(1'b0, 6'h3F, 8'h00, 8'hFF, 1'b0);
      run_xfer(1'b0, 6'h21, 8'h00, 8'h00, 1'b0);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks = checks + 1;
         fails = fails + 1;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule